// File: doc/BRIEF.md
# Link-layer packet framer

The framer takes a transaction-layer packet and turns it into the byte stream a serial link transmits. The packet arrives as 32-bit words with start and end markers. With the first word come sideband fields that give the header length in words, the payload length in words and whether an end-to-end CRC word follows the payload. The framer puts a start symbol in front of the packet, then a two-byte sequence field. Next come the packet words, most significant byte first, then a 32-bit link CRC and an end symbol. Output is one byte per cycle. A control flag marks the two framing symbols.

The sequence counter moves forward once for each packet that is framed and wraps at its 12-bit limit. A packet that declares a bad header or payload length is not framed. The framer still consumes its words up to the end marker, raises a one-cycle error pulse and leaves the sequence counter unchanged. The output side has no back-pressure. The input side is throttled with a ready signal, because each word takes four output cycles and the added bytes take cycles of their own.

Top module: `lnk_framer`

## Requirements
- R1: A framed packet appears on consecutive valid cycles in this order: the start symbol, the upper sequence byte, the lower sequence byte, the content bytes (each word's bits 31:24 first, bits 7:0 last), four link CRC bytes, and the end symbol. The cycle after the end symbol has no valid output.
- R2: The start symbol is byte 0xFB and the end symbol is byte 0xFD. `out_ctrl_o` is high on exactly those two bytes and low on every other valid byte.
- R3: The 16-bit sequence field holds the sequence number in bits 11:0, and bits 15:12 are zero. The first packet after reset carries 0. Each framed packet carries the previous number plus one, and 4095 is followed by 0.
- R4: The link CRC is CRC-32 with polynomial 0x04C11DB7 and seed 0xFFFFFFFF. It processes each byte from bit 7 down to bit 0, covers the two sequence bytes and all content bytes in transmit order, and is sent inverted, bits 31:24 first.
- R5: A packet whose header length is 3 or 4 and whose payload length is 0 to 1024 carries exactly header + payload + (1 if `in_ecrc_i`) content words. The lengths are taken from the first word's cycle.
- R6: A packet declaring any other header length, or a payload length above 1024, produces no output bytes. Its words are consumed up to and including the one with `in_eop_i`. `err_o` pulses high for one cycle, the cycle after the first word is taken. The sequence number does not advance.
- R7: `in_ready_o` is low in every cycle that carries a framing symbol, a sequence byte or a link CRC byte.
- R8: A word offered without `in_sop_i` while no packet is in progress is consumed and discarded. It produces no output and leaves the sequence number unchanged.
- R9: During and right after reset, `out_valid_o` and `err_o` are low and `in_ready_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input word valid |
| in_ready_o | output | 1 | Framer takes the word this cycle |
| in_sop_i | input | 1 | First word of a packet |
| in_eop_i | input | 1 | Last word of a packet |
| in_data_i | input | 32 | Packet word |
| in_hdr_dw_i | input | 3 | Header length in words, valid with the first word |
| in_pay_dw_i | input | 11 | Payload length in words, valid with the first word |
| in_ecrc_i | input | 1 | An end-to-end CRC word follows the payload, valid with the first word |
| out_valid_o | output | 1 | Output byte valid |
| out_data_o | output | 8 | Output byte |
| out_ctrl_o | output | 1 | Output byte is a framing symbol |
| err_o | output | 1 | One-cycle pulse for a dropped packet |

## Verification
The assertions assume that the end marker of an accepted packet sits on the word the declared lengths point to. They also assume that the sideband length fields are stable with the first word. The framer takes its word count from the lengths and never reads the end marker inside an accepted packet, so a mismatch would desynchronize the stream. The bench always derives the number of words it drives from the same lengths it declares. It sets the end marker only on the last of those words. The only exception is a rejected packet, which it ends after a few words, and there the marker is the one thing the framer follows.

// File: rtl/fr_pkg.sv
package fr_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_SOF, ST_SEQH, ST_SEQL, ST_BYTE, ST_WAIT, ST_CRC, ST_EOF, ST_DROP
  } fr_state_e;

  localparam logic [7:0]  SYM_START = 8'hFB;
  localparam logic [7:0]  SYM_END   = 8'hFD;
  localparam logic [31:0] CRC_POLY  = 32'h04C11DB7;
  localparam logic [31:0] CRC_SEED  = 32'hFFFFFFFF;
endpackage

// File: rtl/fr_crc_step.sv
module fr_crc_step #(
  parameter logic [31:0] POLY = 32'h04C11DB7,
  parameter int          DW   = 8
) (
  input  logic [31:0]   crc_i,
  input  logic [DW-1:0] dat_i,
  output logic [31:0]   crc_o
);
  logic [DW:0][31:0] chain;

  assign chain[0] = crc_i;
  for (genvar b = 0; b < DW; b++) begin : g_bit
    logic fb;
    assign fb          = chain[b][31] ^ dat_i[DW-1-b];
    assign chain[b+1]  = {chain[b][30:0], 1'b0} ^ (fb ? POLY : 32'h0);
  end
  assign crc_o = chain[DW];
endmodule

// File: rtl/fr_seq_ctr.sv
module fr_seq_ctr #(
  parameter int SEQ_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  output logic [SEQ_W-1:0] seq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    seq_o <= '0;
    else if (adv_i) seq_o <= seq_o + 1'b1; // natural wrap
  end
endmodule

// File: rtl/fr_len_chk.sv
module fr_len_chk #(
  parameter int HDR_W   = 3,
  parameter int HDR_MIN = 3,
  parameter int HDR_MAX = 4,
  parameter int MAX_PAY = 1024,
  parameter int PAY_W   = $clog2(MAX_PAY + 1),
  parameter int CNT_W   = $clog2(MAX_PAY + HDR_MAX + 2)
) (
  input  logic [HDR_W-1:0] hdr_dw_i,
  input  logic [PAY_W-1:0] pay_dw_i,
  input  logic             ecrc_i,
  output logic             ok_o,
  output logic [CNT_W-1:0] words_o
);
  logic hdr_ok, pay_ok;

  assign hdr_ok  = (int'(hdr_dw_i) >= HDR_MIN) && (int'(hdr_dw_i) <= HDR_MAX);
  assign pay_ok  = int'(pay_dw_i) <= MAX_PAY;
  assign ok_o    = hdr_ok && pay_ok;
  assign words_o = CNT_W'(hdr_dw_i) + CNT_W'(pay_dw_i) + CNT_W'(ecrc_i);
endmodule

// File: rtl/lnk_framer.sv
module lnk_framer
  import fr_pkg::*;
#(
  parameter int SEQ_W   = 12,
  parameter int HDR_W   = 3,
  parameter int MAX_PAY = 1024,
  parameter int PAY_W   = $clog2(MAX_PAY + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  input  logic             in_sop_i,
  input  logic             in_eop_i,
  input  logic [31:0]      in_data_i,
  input  logic [HDR_W-1:0] in_hdr_dw_i,
  input  logic [PAY_W-1:0] in_pay_dw_i,
  input  logic             in_ecrc_i,
  output logic             out_valid_o,
  output logic [7:0]       out_data_o,
  output logic             out_ctrl_o,
  output logic             err_o
);
  localparam int CNT_W = $clog2(MAX_PAY + 4 + 2);

  fr_state_e        state_q;
  logic [31:0]      word_q, crc_q, crc_nxt;
  logic [1:0]       idx_q;
  logic [CNT_W-1:0] rem_q, words;
  logic             len_ok, take, last_byte, crc_en;
  logic [SEQ_W-1:0] seq;
  logic [15:0]      seq_field;

  fr_len_chk #(
    .HDR_W(HDR_W), .HDR_MIN(3), .HDR_MAX(4), .MAX_PAY(MAX_PAY),
    .PAY_W(PAY_W), .CNT_W(CNT_W)
  ) u_len (
    .hdr_dw_i(in_hdr_dw_i), .pay_dw_i(in_pay_dw_i), .ecrc_i(in_ecrc_i),
    .ok_o(len_ok), .words_o(words)
  );

  fr_seq_ctr #(.SEQ_W(SEQ_W)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .adv_i(state_q == ST_EOF), .seq_o(seq)
  );

  fr_crc_step #(.POLY(CRC_POLY), .DW(8)) u_crc (
    .crc_i(crc_q), .dat_i(out_data_o), .crc_o(crc_nxt)
  );

  assign seq_field = 16'(seq);
  assign last_byte = (idx_q == 2'd3);
  assign in_ready_o = (state_q == ST_IDLE) || (state_q == ST_WAIT) || (state_q == ST_DROP) ||
                      (state_q == ST_BYTE && last_byte && rem_q != '0);
  assign take   = in_valid_i && in_ready_o;
  assign crc_en = (state_q == ST_SEQH) || (state_q == ST_SEQL) || (state_q == ST_BYTE);

  always_comb begin
    out_valid_o = 1'b1;
    out_ctrl_o  = 1'b0;
    out_data_o  = 8'h00;
    unique case (state_q)
      ST_SOF:  begin out_ctrl_o = 1'b1; out_data_o = SYM_START; end
      ST_SEQH: out_data_o = seq_field[15:8];
      ST_SEQL: out_data_o = seq_field[7:0];
      ST_BYTE: out_data_o = word_q[31:24];
      ST_CRC:  out_data_o = ~crc_q[31:24];
      ST_EOF:  begin out_ctrl_o = 1'b1; out_data_o = SYM_END; end
      default: out_valid_o = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      word_q  <= '0;
      crc_q   <= CRC_SEED;
      idx_q   <= '0;
      rem_q   <= '0;
      err_o   <= 1'b0;
    end else begin
      err_o <= 1'b0;
      if (crc_en) crc_q <= crc_nxt;
      unique case (state_q)
        ST_IDLE: begin
          if (take && in_sop_i) begin
            if (!len_ok) begin
              err_o   <= 1'b1;
              state_q <= in_eop_i ? ST_IDLE : ST_DROP;
            end else begin
              word_q  <= in_data_i;
              rem_q   <= words - 1'b1;
              state_q <= ST_SOF;
            end
          end
        end
        ST_SOF: begin
          crc_q   <= CRC_SEED;
          state_q <= ST_SEQH;
        end
        ST_SEQH: state_q <= ST_SEQL;
        ST_SEQL: begin
          idx_q   <= '0;
          state_q <= ST_BYTE;
        end
        ST_BYTE: begin
          word_q <= word_q << 8;
          idx_q  <= idx_q + 1'b1;
          if (last_byte) begin
            if (rem_q == '0) begin
              state_q <= ST_CRC;
            end else if (take) begin
              word_q <= in_data_i;
              rem_q  <= rem_q - 1'b1;
            end else begin
              state_q <= ST_WAIT;
            end
          end
        end
        ST_WAIT: begin
          if (take) begin
            word_q  <= in_data_i;
            rem_q   <= rem_q - 1'b1;
            idx_q   <= '0;
            state_q <= ST_BYTE;
          end
        end
        ST_CRC: begin
          crc_q <= crc_q << 8;
          idx_q <= idx_q + 1'b1;
          if (last_byte) state_q <= ST_EOF;
        end
        ST_EOF:  state_q <= ST_IDLE;
        ST_DROP: if (take && in_eop_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lnk_framer_chk.sv
module lnk_framer_chk #(
  parameter int SEQ_W = 12,
  parameter int HDR_W = 3,
  parameter int PAY_W = 11
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             in_valid_i,
  input logic             in_ready_o,
  input logic             in_sop_i,
  input logic             in_eop_i,
  input logic [31:0]      in_data_i,
  input logic [HDR_W-1:0] in_hdr_dw_i,
  input logic [PAY_W-1:0] in_pay_dw_i,
  input logic             in_ecrc_i,
  input logic             out_valid_o,
  input logic [7:0]       out_data_o,
  input logic             out_ctrl_o,
  input logic             err_o
);
  logic             sof_now, sof1_q, sof2_q, have_q;
  logic [7:0]       d1_q;
  logic [SEQ_W-1:0] last_q, seq_seen;

  assign sof_now  = out_valid_o && out_ctrl_o && out_data_o == 8'hFB;
  assign seq_seen = SEQ_W'({d1_q, out_data_o});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sof1_q <= 1'b0; sof2_q <= 1'b0; have_q <= 1'b0;
      d1_q   <= '0;   last_q <= '0;
    end else begin
      sof1_q <= sof_now;
      sof2_q <= sof1_q;
      d1_q   <= out_data_o;
      if (sof2_q) begin
        have_q <= 1'b1;
        last_q <= seq_seen;
      end
    end
  end

  p_ctrl_sym_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_ctrl_o |-> (out_data_o == 8'hFB || out_data_o == 8'hFD));

  p_ready_low_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_ctrl_o |-> !in_ready_o);

  p_seq_top_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof1_q |-> out_valid_o && !out_ctrl_o && !in_ready_o && (out_data_o >> (SEQ_W - 8)) == 8'h0);

  p_seq_first_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof2_q && !have_q |-> seq_seen == '0);

  p_seq_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof2_q && have_q |-> seq_seen == SEQ_W'(last_q + 1'b1));

  p_eof_gap_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_ctrl_o && out_data_o == 8'hFD |=> !out_valid_o);

  p_err_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !out_valid_o);
endmodule

bind lnk_framer lnk_framer_chk #(.SEQ_W(SEQ_W), .HDR_W(HDR_W), .PAY_W(PAY_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .in_valid_i(in_valid_i), .in_ready_o(in_ready_o),
  .in_sop_i(in_sop_i), .in_eop_i(in_eop_i), .in_data_i(in_data_i),
  .in_hdr_dw_i(in_hdr_dw_i), .in_pay_dw_i(in_pay_dw_i), .in_ecrc_i(in_ecrc_i),
  .out_valid_o(out_valid_o), .out_data_o(out_data_o), .out_ctrl_o(out_ctrl_o),
  .err_o(err_o)
);

// File: tb/sim_lnk_framer.sv
module sim_lnk_framer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0, in_ecrc = 1'b0;
  logic [31:0] in_data = '0;
  logic [2:0]  in_hdr = '0;
  logic [10:0] in_pay = '0;
  logic        in_ready, out_valid, out_ctrl, err;
  logic [7:0]  out_data;

  always #5 clk = ~clk;

  lnk_framer u0 (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .in_sop_i(in_sop), .in_eop_i(in_eop), .in_data_i(in_data),
    .in_hdr_dw_i(in_hdr), .in_pay_dw_i(in_pay), .in_ecrc_i(in_ecrc),
    .out_valid_o(out_valid), .out_data_o(out_data), .out_ctrl_o(out_ctrl), .err_o(err)
  );

  // kind: 0 symbol, 1 sequence, 2 content, 3 link crc
  typedef struct packed { logic [1:0] kind; logic ctrl; logic [7:0] d; } exp_t;
  exp_t exp_q[$];

  int total = 0, bad = 0, nbytes = 0, nerr = 0, exp_err = 0, pkt_id = 0, cycles = 0;
  int exp_seq = 0;
  bit done = 0;

  function automatic logic [31:0] crc_b(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r = c;
    for (int i = 7; i >= 0; i--) begin
      logic f;
      f = r[31] ^ d[i];
      r = {r[30:0], 1'b0};
      if (f) r = r ^ 32'h04C11DB7;
    end
    return r;
  endfunction

  function automatic logic [31:0] word_of(input int p, input int i);
    return {p[15:0], i[15:0]} ^ 32'hA5C3_1E69;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, expv);
    end
  endtask

  function automatic string tag_of(input logic [1:0] k);
    case (k)
      2'd0: return "R1 R2 symbol";
      2'd1: return "R3 sequence";
      2'd2: return "R1 R5 content";
      default: return "R4 link crc";
    endcase
  endfunction

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (err) nerr++;
      if (out_valid) begin
        nbytes++;
        if (exp_q.size() == 0) begin
          chk(0, "R1 R6 R8 unexpected byte", {23'h0, out_ctrl, out_data}, 32'h0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          chk({out_ctrl, out_data} == {e.ctrl, e.d}, tag_of(e.kind),
              {23'h0, out_ctrl, out_data}, {23'h0, e.ctrl, e.d});
          if (e.kind != 2'd2)
            chk(!in_ready, "R7 ready during added byte", {31'h0, in_ready}, 32'h0);
        end
      end
    end
  end

  // caller sits at a negedge; returns at a negedge
  task automatic drive_word(input logic [31:0] d, input bit sop, input bit eop,
                            input int hdr, input int pay, input bit ecrc);
    in_valid = 1'b1; in_data = d; in_sop = sop; in_eop = eop;
    in_hdr = 3'(hdr); in_pay = 11'(pay); in_ecrc = ecrc;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
  endtask

  task automatic push_b(input logic [1:0] k, input logic c, input logic [7:0] d);
    exp_t e;
    e.kind = k; e.ctrl = c; e.d = d;
    exp_q.push_back(e);
  endtask

  task automatic send_pkt(input int hdr, input int pay, input bit ecrc, input int bad_words);
    bit good;
    int n;
    logic [31:0] c;
    logic [15:0] sf;
    good = (hdr == 3 || hdr == 4) && pay <= 1024;
    n = good ? hdr + pay + (ecrc ? 1 : 0) : bad_words;
    if (good) begin
      sf = 16'(exp_seq);
      c  = 32'hFFFFFFFF;
      push_b(2'd0, 1'b1, 8'hFB);
      push_b(2'd1, 1'b0, sf[15:8]); c = crc_b(c, sf[15:8]);
      push_b(2'd1, 1'b0, sf[7:0]);  c = crc_b(c, sf[7:0]);
      for (int i = 0; i < n; i++) begin
        logic [31:0] w;
        w = word_of(pkt_id, i);
        for (int b = 3; b >= 0; b--) begin
          push_b(2'd2, 1'b0, w[8*b +: 8]);
          c = crc_b(c, w[8*b +: 8]);
        end
      end
      c = ~c;
      for (int b = 3; b >= 0; b--) push_b(2'd3, 1'b0, c[8*b +: 8]);
      push_b(2'd0, 1'b1, 8'hFD);
      exp_seq = (exp_seq + 1) % 4096;
    end else begin
      exp_err++;
    end
    for (int i = 0; i < n; i++)
      drive_word(word_of(pkt_id, i), i == 0, i == n - 1, hdr, pay, ecrc);
    pkt_id++;
  endtask

  task automatic drain();
    int lim = 0;
    while (exp_q.size() != 0 && lim < 10000) begin
      @(negedge clk);
      lim++;
    end
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R1 all expected bytes seen", exp_q.size(), 0);
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 190000) begin
        done = 1;
        bad++; total++;
        $display("FAIL watchdog act=%0d exp=<190000", cycles);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    int nb0, ne0;
    repeat (3) @(negedge clk);
    chk(!out_valid, "R9 reset out_valid", out_valid, 0);
    chk(!err, "R9 reset err", err, 0);
    chk(in_ready, "R9 reset ready", in_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!out_valid && !err && in_ready, "R9 after reset", {out_valid, err, in_ready}, 3'b001);

    // R5: length mixes
    send_pkt(3, 0, 0, 0);
    send_pkt(4, 0, 0, 0);
    send_pkt(3, 1, 1, 0);
    send_pkt(4, 5, 0, 0);
    send_pkt(4, 2, 1, 0);
    drain();

    // R8: stray words while idle
    nb0 = nbytes;
    drive_word(32'hDEAD_BEEF, 0, 0, 3, 0, 0);
    drive_word(32'h1234_5678, 0, 1, 3, 0, 0);
    repeat (6) @(negedge clk);
    chk(nbytes == nb0, "R8 stray words output", nbytes, nb0);
    send_pkt(3, 2, 0, 0);
    drain();

    // R6: bad lengths
    nb0 = nbytes; ne0 = nerr;
    send_pkt(5, 0, 0, 3);
    send_pkt(2, 0, 0, 1);
    send_pkt(4, 1025, 0, 2);
    repeat (6) @(negedge clk);
    chk(nbytes == nb0, "R6 dropped output", nbytes, nb0);
    chk(nerr - ne0 == 3, "R6 error pulses", nerr - ne0, 3);
    send_pkt(4, 0, 1, 0);
    drain();

    // R5 max payload
    send_pkt(3, 1024, 1, 0);
    drain();

    // R3 wrap: run sequence past 4095
    while (exp_seq != 4094) begin
      send_pkt(3, 0, 0, 0);
      if (exp_q.size() > 64) drain();
    end
    send_pkt(3, 0, 0, 0);
    send_pkt(3, 0, 0, 0);
    send_pkt(4, 1, 0, 0);
    drain();
    chk(exp_seq == 1, "R3 wrap reached", exp_seq, 1);
    chk(nerr == exp_err, "R6 total error pulses", nerr, exp_err);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule